// File: doc/BRIEF.md
# Drive power mode controller

This block holds the power state of a disk drive's built-in controller, along with its read-ahead cache switch. It sits behind the register file of the drive. It receives one already-decoded command per cycle: the opcode, the value in the sector count register, and the value in the write precompensation register. From these it decides whether the spindle motor and the read/write electronics are powered. The four states are active, idle, standby and sleep.

A read or write command moves the block into active mode. When the media engine pulses its completion strobe, the block falls back to idle. Host power commands select standby, idle or sleep directly. Two of them also load an auto-power-down delay, counted in 5-second ticks from an external tick pulse. When that delay is spent in idle with no command, the block drops to standby on its own.

One command reports whether the spindle is up to speed, and the answer depends on a spin-up window that follows every motor start. A cache command switches read-ahead on or off, depending on a key value in the precompensation register. Sleep can only be left through the hardware reset or the software reset. While sleeping, the block ignores every command and raises no interrupt.

Top module: `drive_pwr_ctrl`

## Requirements
- R1: After `rst_n` low or a `softReset` pulse, the outputs are: `powerMode`=0 (idle), `readAhead`=1, `abortFlag`=0, `irq`=0 and `countResult`=0. Auto-power-down is disabled, and a spin-up window of SPIN_CYCLES clocks begins.
- R2: The `powerMode` encoding is 0 idle, 1 active, 2 standby and 3 sleep. `motorOn` is 1 in idle and active only. `rwOn` is 1 in active only.
- R3: An accepted opcode in the range 0x20 to 0x3F (read/write) makes `powerMode` equal 1 in the next cycle. An `opDone` pulse while active returns the mode to 0 in the next cycle.
- R4: Opcode 0xE0 enters standby and opcode 0xE1 enters idle, both in the next cycle. Repeating either opcode in its own mode leaves the mode unchanged.
- R5: Opcodes 0xE2 (go to standby) and 0xE3 (go to idle) load the auto-power-down delay from `cmdCount`, in ticks. A value of 0 disables the timer, values 1 to 11 become 12 ticks, and any other value N becomes N ticks.
- R6: With the timer enabled, the mode changes from idle to standby one cycle after the `idleTick` pulse that completes the delay. Any accepted command, or leaving idle, restarts the count.
- R7: Opcode 0xE5 sets `countResult` to 0xFF when the motor is on and at least SPIN_CYCLES clocks have passed since the motor started. Otherwise it sets `countResult` to 0x00. A motor start is any reset, or any move out of standby into idle or active.
- R8: Opcode 0xE6 enters sleep. While in sleep, every command and every `opDone` pulse is ignored: the mode, `readAhead` and `abortFlag` keep their values and `irq` stays low. Only a reset leaves sleep.
- R9: Opcode 0xEF with a precompensation value of 0xAA sets `readAhead`, and with 0x55 clears it. Any other value sets `abortFlag` and leaves `readAhead` unchanged. `abortFlag` clears on the next accepted command.
- R10: When `irqEnable` is 1, `irq` rises one cycle after an accepted power command (0xE0, 0xE1, 0xE2, 0xE3, 0xE5, 0xE6 or 0xEF) and stays high until `irqAck`. No other opcode raises it.
- R11: A read/write command received in standby powers the motor and the read/write circuits back up. The mode becomes active, and a new spin-up window begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| softReset | input | 1 | Synchronous software reset pulse |
| cmdValid | input | 1 | A command is written this cycle |
| cmdCode | input | 8 | Command opcode |
| cmdCount | input | UNIT_W | Sector count register value |
| cmdPrecomp | input | 8 | Precompensation register value |
| opDone | input | 1 | Read/write command completed |
| idleTick | input | 1 | One pulse per 5-second unit |
| irqEnable | input | 1 | Interrupt enable |
| irqAck | input | 1 | Interrupt acknowledge (status read) |
| powerMode | output | 2 | Current power state |
| motorOn | output | 1 | Spindle motor powered |
| rwOn | output | 1 | Read/write circuits powered |
| readAhead | output | 1 | Read-ahead cache enabled |
| countResult | output | UNIT_W | Result of the power-mode query |
| abortFlag | output | 1 | Last command aborted |
| irq | output | 1 | Interrupt request |

## Verification
The bench exercises the timer in four ways, and each one tells a different fault apart:
- A short delay value checks the 12-tick floor.
- A long value interrupted by a command midway checks that any command restarts the count.
- A zero value checks that the timer is disabled.
- An exact count of ticks before and after the boundary catches an off-by-one expiry.

The mode query is issued during and after spin-up, and also in standby, which separates the motor-state test from the spin-up window. The cache command is tried with both key values and a wrong value, which distinguishes the abort path from a silent change. A burst of commands in sleep, followed by a software reset, shows that sleep is sticky while the reset still wins.

// File: rtl/drive_pwr_pkg.sv
package drive_pwr_pkg;

  typedef enum logic [1:0] {
    PM_IDLE    = 2'd0,
    PM_ACTIVE  = 2'd1,
    PM_STANDBY = 2'd2,
    PM_SLEEP   = 2'd3
  } pwrMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadDelay;
    logic raOn;
    logic raOff;
    logic report;
    logic startSpin;
    logic clearIdle;
  } dpCtl_t;

  localparam logic [7:0] OP_STANDBY_NOW = 8'hE0;
  localparam logic [7:0] OP_IDLE_NOW    = 8'hE1;
  localparam logic [7:0] OP_STANDBY_TMR = 8'hE2;
  localparam logic [7:0] OP_IDLE_TMR    = 8'hE3;
  localparam logic [7:0] OP_QUERY       = 8'hE5;
  localparam logic [7:0] OP_SLEEP       = 8'hE6;
  localparam logic [7:0] OP_CACHE       = 8'hEF;
  localparam logic [7:0] KEY_RA_ON      = 8'hAA;
  localparam logic [7:0] KEY_RA_OFF     = 8'h55;

endpackage

// File: rtl/drive_pwr_ctl.sv
module drive_pwr_ctl
  import drive_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       softReset,
  input  logic       cmdValid,
  input  logic [7:0] cmdCode,
  input  logic [7:0] cmdPrecomp,
  input  logic       opDone,
  input  logic       irqEnable,
  input  logic       irqAck,
  input  logic       tmrExpire,
  output pwrMode_e   mode,
  output logic       abortFlag,
  output logic       irq,
  output dpCtl_t     strb
);

  pwrMode_e nextMode;
  logic     accept;
  logic     isPower;
  logic     badParam;
  logic     fromStandby;

  assign accept      = cmdValid && (mode != PM_SLEEP);
  assign fromStandby = (mode == PM_STANDBY);

  always_comb begin
    nextMode = mode;
    strb     = '0;
    isPower  = 1'b0;
    badParam = 1'b0;
    if (accept) begin
      strb.clearIdle = 1'b1;
      case (cmdCode)
        OP_STANDBY_NOW: begin
          isPower  = 1'b1;
          nextMode = PM_STANDBY;
        end
        OP_IDLE_NOW: begin
          isPower        = 1'b1;
          nextMode       = PM_IDLE;
          strb.startSpin = fromStandby;
        end
        OP_STANDBY_TMR: begin
          isPower        = 1'b1;
          nextMode       = PM_STANDBY;
          strb.loadDelay = 1'b1;
        end
        OP_IDLE_TMR: begin
          isPower        = 1'b1;
          nextMode       = PM_IDLE;
          strb.loadDelay = 1'b1;
          strb.startSpin = fromStandby;
        end
        OP_QUERY: begin
          isPower     = 1'b1;
          strb.report = 1'b1;
        end
        OP_SLEEP: begin
          isPower  = 1'b1;
          nextMode = PM_SLEEP;
        end
        OP_CACHE: begin
          isPower = 1'b1;
          if (cmdPrecomp == KEY_RA_ON)       strb.raOn  = 1'b1;
          else if (cmdPrecomp == KEY_RA_OFF) strb.raOff = 1'b1;
          else                               badParam   = 1'b1;
        end
        default: begin
          if (cmdCode[7:5] == 3'b001) begin
            nextMode       = PM_ACTIVE;
            strb.startSpin = fromStandby;
          end
        end
      endcase
    end else if (opDone && mode == PM_ACTIVE) begin
      nextMode = PM_IDLE;
    end else if (tmrExpire) begin
      nextMode = PM_STANDBY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= PM_IDLE;
      abortFlag <= 1'b0;
      irq       <= 1'b0;
    end else if (softReset) begin
      mode      <= PM_IDLE;
      abortFlag <= 1'b0;
      irq       <= 1'b0;
    end else begin
      mode <= nextMode;
      if (accept) abortFlag <= badParam;
      if (accept && isPower && irqEnable) irq <= 1'b1;
      else if (irqAck)                     irq <= 1'b0;
    end
  end

  // R8: sleep is left only through reset
  a_r8_sleep_sticky: assert property (@(posedge clk) disable iff (!rst_n || softReset)
    mode == PM_SLEEP |=> mode == PM_SLEEP);

  // R8: no interrupt raised while asleep
  a_r8_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n || softReset)
    (mode == PM_SLEEP && !irq) |=> !irq);

  // R9: wrong cache key aborts
  a_r9_bad_key_aborts: assert property (@(posedge clk) disable iff (!rst_n || softReset)
    (cmdValid && mode != PM_SLEEP && cmdCode == OP_CACHE &&
     cmdPrecomp != KEY_RA_ON && cmdPrecomp != KEY_RA_OFF) |=> abortFlag);

  // R6: idle holds without a command or timer expiry
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n || softReset)
    (mode == PM_IDLE && !cmdValid && !tmrExpire) |=> mode == PM_IDLE);

  // R3: completion leaves active mode
  a_r3_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n || softReset)
    (mode == PM_ACTIVE && opDone && !cmdValid) |=> mode == PM_IDLE);

  // R10: no interrupt rises while disabled
  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n || softReset)
    (!irq && !irqEnable) |=> !irq);

endmodule

// File: rtl/drive_pwr_dp.sv
module drive_pwr_dp
  import drive_pwr_pkg::*;
#(
  parameter int UNIT_W      = 8,
  parameter int MIN_UNITS   = 12,
  parameter int SPIN_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              softReset,
  input  dpCtl_t            strb,
  input  logic [UNIT_W-1:0] cmdCount,
  input  logic              idleTick,
  input  logic              inIdle,
  input  logic              motorOn,
  output logic              tmrExpire,
  output logic              readAhead,
  output logic [UNIT_W-1:0] countResult
);

  localparam int SPIN_W = $clog2(SPIN_CYCLES + 1);
  localparam logic [UNIT_W-1:0] MIN_VAL  = UNIT_W'(MIN_UNITS);
  localparam logic [SPIN_W-1:0] SPIN_VAL = SPIN_W'(SPIN_CYCLES);

  logic [UNIT_W-1:0] delayUnits;
  logic [UNIT_W-1:0] idleCnt;
  logic [UNIT_W-1:0] delayNext;
  logic [SPIN_W-1:0] spinCnt;
  logic              tmrOn;

  assign tmrOn     = (delayUnits != '0);
  assign tmrExpire = idleTick && tmrOn && inIdle && (idleCnt == delayUnits - UNIT_W'(1));

  always_comb begin
    if (cmdCount == '0)          delayNext = '0;
    else if (cmdCount < MIN_VAL) delayNext = MIN_VAL;
    else                         delayNext = cmdCount;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delayUnits  <= '0;
      idleCnt     <= '0;
      spinCnt     <= SPIN_VAL;
      readAhead   <= 1'b1;
      countResult <= '0;
    end else if (softReset) begin
      delayUnits  <= '0;
      idleCnt     <= '0;
      spinCnt     <= SPIN_VAL;
      readAhead   <= 1'b1;
      countResult <= '0;
    end else begin
      if (strb.loadDelay) delayUnits <= delayNext;

      if (strb.clearIdle || !inIdle) idleCnt <= '0;
      else if (idleTick && tmrOn)    idleCnt <= tmrExpire ? '0 : idleCnt + UNIT_W'(1);

      if (strb.startSpin)       spinCnt <= SPIN_VAL;
      else if (spinCnt != '0)   spinCnt <= spinCnt - SPIN_W'(1);

      if (strb.raOn)       readAhead <= 1'b1;
      else if (strb.raOff) readAhead <= 1'b0;

      if (strb.report) countResult <= (motorOn && spinCnt == '0) ? '1 : '0;
    end
  end

  // R5: a nonzero delay never falls below the floor
  a_r5_delay_floor: assert property (@(posedge clk) disable iff (!rst_n || softReset)
    (strb.loadDelay && cmdCount != '0) |=> delayUnits >= MIN_VAL);

  // R6: the idle count stays below the programmed delay
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n || softReset)
    tmrOn |-> idleCnt < delayUnits);

  // R7: query with the motor off reports zero
  a_r7_query_off: assert property (@(posedge clk) disable iff (!rst_n || softReset)
    (strb.report && !motorOn) |=> countResult == '0);

endmodule

// File: rtl/drive_pwr_ctrl.sv
module drive_pwr_ctrl
  import drive_pwr_pkg::*;
#(
  parameter int UNIT_W      = 8,
  parameter int MIN_UNITS   = 12,
  parameter int SPIN_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              softReset,
  input  logic              cmdValid,
  input  logic [7:0]        cmdCode,
  input  logic [UNIT_W-1:0] cmdCount,
  input  logic [7:0]        cmdPrecomp,
  input  logic              opDone,
  input  logic              idleTick,
  input  logic              irqEnable,
  input  logic              irqAck,
  output logic [1:0]        powerMode,
  output logic              motorOn,
  output logic              rwOn,
  output logic              readAhead,
  output logic [UNIT_W-1:0] countResult,
  output logic              abortFlag,
  output logic              irq
);

  pwrMode_e mode;
  dpCtl_t   strb;
  logic     tmrExpire;

  assign powerMode = mode;
  assign motorOn   = (mode == PM_IDLE) || (mode == PM_ACTIVE);
  assign rwOn      = (mode == PM_ACTIVE);

  drive_pwr_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .softReset(softReset),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdPrecomp(cmdPrecomp),
    .opDone(opDone), .irqEnable(irqEnable), .irqAck(irqAck),
    .tmrExpire(tmrExpire), .mode(mode), .abortFlag(abortFlag),
    .irq(irq), .strb(strb)
  );

  drive_pwr_dp #(
    .UNIT_W(UNIT_W), .MIN_UNITS(MIN_UNITS), .SPIN_CYCLES(SPIN_CYCLES)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .softReset(softReset), .strb(strb),
    .cmdCount(cmdCount), .idleTick(idleTick), .inIdle(mode == PM_IDLE),
    .motorOn(motorOn), .tmrExpire(tmrExpire), .readAhead(readAhead),
    .countResult(countResult)
  );

  // R2: read/write circuits never powered without the motor
  a_r2_rw_needs_motor: assert property (@(posedge clk) disable iff (!rst_n)
    rwOn |-> motorOn);

endmodule

// File: tb/tb_drive_pwr_ctrl.sv
module tb_drive_pwr_ctrl;

  localparam int SPIN = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       softReset = 1'b0;
  logic       cmdValid = 1'b0;
  logic [7:0] cmdCode = '0;
  logic [7:0] cmdCount = '0;
  logic [7:0] cmdPrecomp = '0;
  logic       opDone = 1'b0;
  logic       idleTick = 1'b0;
  logic       irqEnable = 1'b0;
  logic       irqAck = 1'b0;
  logic [1:0] powerMode;
  logic       motorOn, rwOn, readAhead, abortFlag, irq;
  logic [7:0] countResult;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  drive_pwr_ctrl #(.UNIT_W(8), .MIN_UNITS(12), .SPIN_CYCLES(SPIN)) dut (
    .clk(clk), .rst_n(rst_n), .softReset(softReset), .cmdValid(cmdValid),
    .cmdCode(cmdCode), .cmdCount(cmdCount), .cmdPrecomp(cmdPrecomp),
    .opDone(opDone), .idleTick(idleTick), .irqEnable(irqEnable), .irqAck(irqAck),
    .powerMode(powerMode), .motorOn(motorOn), .rwOn(rwOn), .readAhead(readAhead),
    .countResult(countResult), .abortFlag(abortFlag), .irq(irq)
  );

  // behavioural reference model
  int mMode, mLimit, mIdle, mSpin, mResult, oldSpin, oldMode;
  bit mRa, mAbort, mIrq, acc, expd;

  function automatic bit isPow(input logic [7:0] c);
    return c == 8'hE0 || c == 8'hE1 || c == 8'hE2 || c == 8'hE3 ||
           c == 8'hE5 || c == 8'hE6 || c == 8'hEF;
  endfunction

  task automatic mReset();
    mMode = 0; mLimit = 0; mIdle = 0; mSpin = SPIN; mResult = 0;
    mRa = 1; mAbort = 0; mIrq = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || softReset) mReset();
    else begin
      oldMode = mMode;
      oldSpin = mSpin;
      acc  = cmdValid && mMode != 3;
      expd = !acc && mMode == 0 && idleTick && mLimit != 0 && mIdle == mLimit - 1;
      if (acc || mMode != 0) mIdle = 0;
      else if (idleTick && mLimit != 0) mIdle = expd ? 0 : mIdle + 1;
      if (mSpin > 0) mSpin = mSpin - 1;
      if (acc && isPow(cmdCode) && irqEnable) mIrq = 1;
      else if (irqAck) mIrq = 0;
      if (acc) begin
        mAbort = 0;
        if (cmdCode >= 8'h20 && cmdCode <= 8'h3F) begin
          mMode = 1; if (oldMode == 2) mSpin = SPIN;
        end else if (cmdCode == 8'hE0) mMode = 2;
        else if (cmdCode == 8'hE1 || cmdCode == 8'hE3) begin
          mMode = 0; if (oldMode == 2) mSpin = SPIN;
        end else if (cmdCode == 8'hE2) mMode = 2;
        else if (cmdCode == 8'hE5)
          mResult = ((oldMode == 0 || oldMode == 1) && oldSpin == 0) ? 255 : 0;
        else if (cmdCode == 8'hE6) mMode = 3;
        else if (cmdCode == 8'hEF) begin
          if (cmdPrecomp == 8'hAA) mRa = 1;
          else if (cmdPrecomp == 8'h55) mRa = 0;
          else mAbort = 1;
        end
        if (cmdCode == 8'hE2 || cmdCode == 8'hE3)
          mLimit = (cmdCount == 0) ? 0 : (cmdCount < 12) ? 12 : int'(cmdCount);
      end else if (opDone && mMode == 1) mMode = 0;
      else if (expd) mMode = 2;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R2 model mode", powerMode, mMode);
      chk("R2 model motor", motorOn, (mMode == 0 || mMode == 1));
      chk("R2 model rw", rwOn, (mMode == 1));
      chk("R9 model readAhead", readAhead, mRa);
      chk("R9 model abort", abortFlag, mAbort);
      chk("R10 model irq", irq, mIrq);
      chk("R7 model result", countResult, mResult);
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic cmd(input logic [7:0] c, input logic [7:0] n, input logic [7:0] p);
    @(negedge clk);
    cmdValid = 1; cmdCode = c; cmdCount = n; cmdPrecomp = p;
    @(negedge clk);
    cmdValid = 0;
  endtask

  task automatic pulseDone();
    @(negedge clk); opDone = 1; @(negedge clk); opDone = 0;
  endtask

  task automatic ack();
    @(negedge clk); irqAck = 1; @(negedge clk); irqAck = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); idleTick = 1; @(negedge clk); idleTick = 0;
    end
  endtask

  task automatic idleWait(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    mReset();
    idleWait(3);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset mode", powerMode, 0);
    chk("R1 reset readAhead", readAhead, 1);
    chk("R1 reset abort", abortFlag, 0);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset result", countResult, 0);

    // R7 spin-up window
    cmd(8'hE5, 0, 0);
    chk("R7 query during spin-up", countResult, 0);
    idleWait(SPIN + 2);
    cmd(8'hE5, 0, 0);
    chk("R7 query spun up", countResult, 255);

    // R4 / R10
    irqEnable = 1;
    cmd(8'hE0, 0, 0);
    chk("R4 standby now", powerMode, 2);
    chk("R2 standby motor off", motorOn, 0);
    chk("R10 irq raised", irq, 1);
    ack();
    chk("R10 irq acked", irq, 0);
    cmd(8'hE0, 0, 0);
    chk("R4 repeat standby", powerMode, 2);
    cmd(8'hE5, 0, 0);
    chk("R7 query in standby", countResult, 0);
    ack();

    // R11 / R3
    cmd(8'h20, 0, 0);
    chk("R11 read wakes to active", powerMode, 1);
    chk("R11 rw circuits on", rwOn, 1);
    chk("R10 no irq for read", irq, 0);
    cmd(8'hE5, 0, 0);
    chk("R11 spin-up restarted", countResult, 0);
    pulseDone();
    chk("R3 done to idle", powerMode, 0);
    cmd(8'h3F, 0, 0);
    chk("R3 write to active", powerMode, 1);
    pulseDone();
    cmd(8'hE1, 0, 0);
    chk("R4 repeat idle", powerMode, 0);

    // R5 / R6 timer
    cmd(8'hE3, 2, 0);
    ticks(11);
    chk("R5 floor not yet", powerMode, 0);
    ticks(1);
    chk("R6 expired at floor", powerMode, 2);
    cmd(8'hE3, 13, 0);
    ticks(6);
    cmd(8'hE5, 0, 0);
    ticks(12);
    chk("R6 restart by command", powerMode, 0);
    ticks(1);
    chk("R6 expired after restart", powerMode, 2);
    cmd(8'hE2, 0, 0);
    chk("R5 standby with timer", powerMode, 2);
    cmd(8'hE1, 0, 0);
    ticks(20);
    chk("R5 zero disables timer", powerMode, 0);

    // R9 cache
    cmd(8'hEF, 0, 8'h55);
    chk("R9 key off", readAhead, 0);
    cmd(8'hEF, 0, 8'h12);
    chk("R9 bad key aborts", abortFlag, 1);
    chk("R9 bad key keeps state", readAhead, 0);
    cmd(8'hEF, 0, 8'hAA);
    chk("R9 key on", readAhead, 1);
    chk("R9 abort cleared", abortFlag, 0);

    // R10 gating
    ack();
    irqEnable = 0;
    cmd(8'hE1, 0, 0);
    chk("R10 disabled no irq", irq, 0);
    irqEnable = 1;
    cmd(8'h90, 0, 0);
    chk("R10 other opcode no irq", irq, 0);

    // R8 sleep
    cmd(8'hE6, 0, 0);
    chk("R8 sleep entered", powerMode, 3);
    ack();
    cmd(8'hE1, 0, 0);
    chk("R8 idle ignored", powerMode, 3);
    chk("R8 no irq in sleep", irq, 0);
    cmd(8'hEF, 0, 8'h55);
    chk("R8 cache ignored", readAhead, 1);
    cmd(8'hEF, 0, 8'h00);
    chk("R8 abort untouched", abortFlag, 0);
    cmd(8'h20, 0, 0);
    pulseDone();
    chk("R8 read ignored", powerMode, 3);
    cmd(8'hEF, 0, 8'h55);
    @(negedge clk); softReset = 1; @(negedge clk); softReset = 0;
    chk("R1 soft reset mode", powerMode, 0);
    chk("R1 soft reset readAhead", readAhead, 1);
    idleWait(4);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule